// File: doc/BRIEF.md
# Tile Row Integer-to-Float Converter

This block holds a small two-dimensional tile of 32-bit words and, on request, pulls out one vector-wide slice of a chosen row, turning each signed integer lane into an IEEE-754 single-precision value. One request produces one registered 512-bit result vector of sixteen lanes. A packed 32-bit selector names the row and the slice within the row. A column-byte count supplied with the request says how much of the row holds live data. Lanes that fall past that count come out as zero.

The tile storage sits inside the block and has a simple word-wide write port, so a surrounding engine or a test can fill it. Conversion always rounds to nearest with ties to even. It never flags exceptions and cannot be told to round any other way.

Top module: `tile_row_i2f`

## Requirements
- R1: The selector `req_sel` splits into a row index in bits 15:0 and a chunk index in bits 31:16. Chunk k covers row words 16k to 16k+15, which is byte offset 64k.
- R2: Output lane i occupies `out_vec[32i+31:32i]` and carries row word (16·chunk + i).
- R3: Lane i is forced to 0x00000000 when 16·chunk + i >= floor(colsb/4). A `req_colsb` above the 64-byte row size counts as 64, and a count that is not a multiple of 4 drops the partial word.
- R4: A chunk index of 1 or more, or a row index of 16 or more, gives an all-zero vector.
- R5: A live lane holds the signed source word converted to fp32 with round-to-nearest, ties-to-even. For example, 16777217 gives 0x4B800000 and 16777219 gives 0x4B800002.
- R6: Integer 0 gives 0x00000000 (+0.0). -2147483648 gives exactly 0xCF000000. 2147483647 gives 0x4F000000, because the rounding carry out of the mantissa raises the exponent.
- R7: `out_valid` is high in exactly the cycle after a cycle with `req_valid` high. `out_vec` keeps its value until the next request.
- R8: With `wr_en` high, `wr_data` is stored at word `wr_word` of row `wr_row` at the clock edge. A request in any later cycle sees the new value.
- R9: While `rst` is high, and after it falls until the first request, `out_valid` is 0 and `out_vec` is all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Conversion request strobe |
| req_sel | input | 32 | Packed selector: chunk index in bits 31:16, row index in bits 15:0 |
| req_colsb | input | 16 | Live bytes per row for this request |
| wr_en | input | 1 | Tile word write enable |
| wr_row | input | 4 | Row written |
| wr_word | input | 4 | Word within the row written |
| wr_data | input | 32 | Word written |
| out_valid | output | 1 | Result valid, one cycle after the request |
| out_vec | output | 512 | Sixteen fp32 lanes |

## Verification
The bench targets the rounding edges: ties just above 2^24, values that round up past a tie, and the full-scale positive value whose rounding carry must move the exponent. A converter that truncated, or one that dropped the carry, would return 0x4EFFFFFF-style values or a wrong exponent. It also feeds the most negative integer and zero, where a design that negates in 32 signed bits or forgets the zero case gives garbage or a denormal-looking word. Partial, zero and oversized column counts, together with out-of-range rows and chunks, are applied to catch off-by-one masking, a missing cap and indexing that wraps into real data instead of producing zeros.

// File: rtl/tri2f_pkg.sv
package tri2f_pkg;
  localparam int WORD_W     = 32;
  localparam int WORD_BYTES = WORD_W / 8;
  typedef logic [WORD_W-1:0] word_t;
  localparam int F32_BIAS   = 127;
  localparam int F32_MANT_W = 23;
endpackage

// File: rtl/tile_bank.sv
module tile_bank #(
  parameter int DEPTH = 16,
  parameter int W     = 32,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/sel_decode.sv
module sel_decode #(
  parameter int ROWS      = 16,
  parameter int ROW_BYTES = 64,
  parameter int VEC_BYTES = 64,
  parameter int COLSB_W   = 16,
  localparam int VEC_WORDS = VEC_BYTES / tri2f_pkg::WORD_BYTES,
  localparam int ROW_WORDS = ROW_BYTES / tri2f_pkg::WORD_BYTES,
  localparam int CPR       = ROW_WORDS / VEC_WORDS,
  localparam int DEPTH     = ROWS * CPR,
  localparam int AW        = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic [31:0]          sel,
  input  logic [COLSB_W-1:0]   colsb,
  output logic [AW-1:0]        rd_addr,
  output logic [VEC_WORDS-1:0] live
);
  logic [15:0] row_idx;
  logic [15:0] chunk_idx;
  logic        in_range;
  logic [31:0] base_word;
  logic [31:0] limit_word;
  logic [31:0] flat_addr;

  assign row_idx   = sel[15:0];
  assign chunk_idx = sel[31:16];

  always_comb begin
    in_range   = (32'(row_idx) < 32'(ROWS)) && (32'(chunk_idx) < 32'(CPR));
    base_word  = 32'(chunk_idx) * 32'(VEC_WORDS);
    if (32'(colsb) > 32'(ROW_BYTES)) limit_word = 32'(ROW_BYTES) / 32'(tri2f_pkg::WORD_BYTES);
    else                             limit_word = 32'(colsb) / 32'(tri2f_pkg::WORD_BYTES);
    flat_addr  = in_range ? (32'(row_idx) * 32'(CPR) + 32'(chunk_idx)) : 32'd0;
    rd_addr    = flat_addr[AW-1:0];
    for (int i = 0; i < VEC_WORDS; i++) begin
      live[i] = in_range && ((base_word + 32'(i)) < limit_word);
    end
  end

  // Live lanes always form a contiguous run starting at lane 0 (R3).
  always_comb begin
    for (int i = 1; i < VEC_WORDS; i++) begin
      a_r3_live_contiguous: assert (!live[i] || live[i-1]);
    end
  end
endmodule

// File: rtl/i2f_conv.sv
module i2f_conv
  import tri2f_pkg::*;
(
  input  word_t din,
  output word_t dout
);
  logic        sgn;
  logic [31:0] mag;
  logic [4:0]  lead;
  logic [31:0] norm;
  logic [23:0] kept;
  logic        guard;
  logic        sticky;
  logic        bump;
  logic [24:0] rounded;
  logic [7:0]  expo;
  logic [22:0] mant;

  always_comb begin
    sgn  = din[31];
    mag  = sgn ? (~din + 32'd1) : din;
    lead = 5'd0;
    for (int b = 0; b < 32; b++) begin
      if (mag[b]) lead = 5'(b);
    end
    norm    = mag << (5'd31 - lead);
    kept    = norm[31:8];
    guard   = norm[7];
    sticky  = |norm[6:0];
    bump    = guard && (sticky || kept[0]);
    rounded = {1'b0, kept} + 25'(bump);
    if (rounded[24]) begin
      expo = 8'(F32_BIAS) + 8'(lead) + 8'd1;
      mant = rounded[23:1];
    end else begin
      expo = 8'(F32_BIAS) + 8'(lead);
      mant = rounded[22:0];
    end
    if (mag == 32'd0) dout = '0;
    else              dout = {sgn, expo, mant};
  end

  always_comb begin
    a_r6_zero_gives_pos_zero: assert (din != '0 || dout == '0);
    a_r5_sign_preserved:      assert (din == '0 || dout[31] == din[31]);
    a_r5_normal_exponent:     assert (din == '0 || (dout[30:23] >= 8'd127 && dout[30:23] <= 8'd158));
  end
endmodule

// File: rtl/tile_row_i2f.sv
module tile_row_i2f #(
  parameter int ROWS      = 16,
  parameter int ROW_BYTES = 64,
  parameter int VEC_BYTES = 64,
  parameter int COLSB_W   = 16,
  localparam int VEC_WORDS = VEC_BYTES / tri2f_pkg::WORD_BYTES,
  localparam int ROW_WORDS = ROW_BYTES / tri2f_pkg::WORD_BYTES,
  localparam int CPR       = ROW_WORDS / VEC_WORDS,
  localparam int DEPTH     = ROWS * CPR,
  localparam int AW        = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int ROW_AW    = (ROWS > 1) ? $clog2(ROWS) : 1,
  localparam int WORD_AW   = (ROW_WORDS > 1) ? $clog2(ROW_WORDS) : 1,
  localparam int VEC_W     = VEC_BYTES * 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req_valid,
  input  logic [31:0]        req_sel,
  input  logic [COLSB_W-1:0] req_colsb,
  input  logic               wr_en,
  input  logic [ROW_AW-1:0]  wr_row,
  input  logic [WORD_AW-1:0] wr_word,
  input  logic [31:0]        wr_data,
  output logic               out_valid,
  output logic [VEC_W-1:0]   out_vec
);
  import tri2f_pkg::*;

  logic [AW-1:0]        rd_addr;
  logic [VEC_WORDS-1:0] live;
  logic [AW-1:0]        wr_addr;
  logic [31:0]          wr_flat;
  logic [VEC_W-1:0]     next_vec;

  always_comb begin
    wr_flat = 32'(wr_row) * 32'(CPR) + 32'(wr_word) / 32'(VEC_WORDS);
    wr_addr = wr_flat[AW-1:0];
  end

  sel_decode #(
    .ROWS(ROWS), .ROW_BYTES(ROW_BYTES), .VEC_BYTES(VEC_BYTES), .COLSB_W(COLSB_W)
  ) u_dec (
    .sel(req_sel), .colsb(req_colsb), .rd_addr(rd_addr), .live(live)
  );

  for (genvar g = 0; g < VEC_WORDS; g++) begin : g_lane
    word_t raw;
    word_t cvt;
    logic  we;

    assign we = wr_en && ((32'(wr_word) % 32'(VEC_WORDS)) == 32'(g));

    tile_bank #(.DEPTH(DEPTH), .W(WORD_W)) u_bank (
      .clk(clk), .we(we), .waddr(wr_addr), .wdata(wr_data),
      .raddr(rd_addr), .rdata(raw)
    );

    i2f_conv u_cvt (.din(raw), .dout(cvt));

    assign next_vec[g*WORD_W +: WORD_W] = live[g] ? cvt : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_vec   <= '0;
    end else begin
      out_valid <= req_valid;
      if (req_valid) out_vec <= next_vec;
    end
  end

  a_r7_valid_follows_req: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> out_valid);
  a_r7_no_spurious_valid: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !out_valid);
  a_r7_vec_held: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> $stable(out_vec));
  a_r4_far_chunk_zero: assert property (@(posedge clk) disable iff (rst)
    (req_valid && (32'(req_sel[31:16]) >= 32'(CPR))) |=> (out_vec == '0));
  a_r4_far_row_zero: assert property (@(posedge clk) disable iff (rst)
    (req_valid && (32'(req_sel[15:0]) >= 32'(ROWS))) |=> (out_vec == '0));
  a_r3_no_cols_zero: assert property (@(posedge clk) disable iff (rst)
    (req_valid && (32'(req_colsb) < 32'(WORD_BYTES))) |=> (out_vec == '0));
endmodule

// File: tb/tile_row_i2f_tb.sv
module tile_row_i2f_tb;
  logic         clk = 1'b0;
  logic         rst;
  logic         req_valid;
  logic [31:0]  req_sel;
  logic [15:0]  req_colsb;
  logic         wr_en;
  logic [3:0]   wr_row;
  logic [3:0]   wr_word;
  logic [31:0]  wr_data;
  logic         out_valid;
  logic [511:0] out_vec;

  int n_checks = 0;
  int n_fails  = 0;
  logic [31:0] mem_m [16][16];
  logic [31:0] lcg = 32'h1234_5678;

  always #10 clk = ~clk;

  tile_row_i2f u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_sel(req_sel),
    .req_colsb(req_colsb), .wr_en(wr_en), .wr_row(wr_row), .wr_word(wr_word),
    .wr_data(wr_data), .out_valid(out_valid), .out_vec(out_vec)
  );

  function automatic logic [31:0] ref_f32(input logic [31:0] v);
    longint m, q, rem, half;
    int s;
    logic sg;
    if (v == 32'd0) return 32'd0;
    sg = v[31];
    m  = sg ? -longint'($signed(v)) : longint'(v);
    s  = 0;
    while ((m >> s) >= 64'd16777216) s++;
    q = m >> s;
    if (s > 0) begin
      rem  = m - (q << s);
      half = longint'(1) << (s - 1);
      if (rem > half || (rem == half && q[0])) q++;
      if (q == 64'd16777216) begin q = q >> 1; s++; end
    end else begin
      while (q < 64'd8388608) begin q = q << 1; s--; end
    end
    return {sg, 8'(150 + s), q[22:0]};
  endfunction

  function automatic logic [31:0] exp_lane(input int row, input int chunk, input int colsb, input int i);
    int lim;
    lim = ((colsb > 64) ? 64 : colsb) / 4;
    if (row >= 16 || chunk * 16 + i >= lim) return 32'd0;
    return ref_f32(mem_m[row][chunk * 16 + i]);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  task automatic wr(input int row, input int word, input logic [31:0] d);
    wr_en = 1'b1; wr_row = 4'(row); wr_word = 4'(word); wr_data = d;
    mem_m[row][word] = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // One request; checks each lane, valid timing and hold (R1, R2, R7).
  task automatic run_req(input string req, input int row, input int chunk, input int colsb);
    logic [511:0] snap;
    req_valid = 1'b1;
    req_sel   = {16'(chunk), 16'(row)};
    req_colsb = 16'(colsb);
    @(negedge clk);
    req_valid = 1'b0;
    req_sel   = 32'hDEAD_BEEF;
    chk("R7 valid", 32'(out_valid), 32'd1);
    for (int i = 0; i < 16; i++) chk(req, out_vec[i*32 +: 32], exp_lane(row, chunk, colsb, i));
    snap = out_vec;
    @(negedge clk);
    chk("R7 drop", 32'(out_valid), 32'd0);
    chk("R7 hold", 32'(out_vec == snap), 32'd1);
  endtask

  task automatic t_reset;
    chk("R9 valid", 32'(out_valid), 32'd0);
    chk("R9 vec", 32'(out_vec == '0), 32'd1);
  endtask

  task automatic t_load;
    logic [31:0] sp [16];
    sp = '{32'd0, 32'd1, 32'hFFFF_FFFF, 32'd16777217, 32'd16777219, 32'h7FFF_FFFF,
           32'h8000_0000, 32'd16777216, 32'd33554435, 32'd123456789, -32'd123456789,
           32'd8388607, 32'h00FF_FFFF, 32'h4000_0001, 32'd100, 32'hFF00_0001};
    for (int w = 0; w < 16; w++) wr(0, w, sp[w]);
    for (int r = 1; r < 16; r++) begin
      for (int w = 0; w < 16; w++) begin
        lcg = lcg * 32'd1664525 + 32'd1013904223;
        wr(r, w, lcg ^ (lcg >> 7));
      end
    end
  endtask

  task automatic t_specials;
    run_req("R5 R6 specials", 0, 0, 64);
    chk("R6 int_min", out_vec[6*32 +: 32], 32'hCF00_0000);
    chk("R6 int_max carry", out_vec[5*32 +: 32], 32'h4F00_0000);
    chk("R5 tie even", out_vec[3*32 +: 32], 32'h4B80_0000);
    chk("R5 tie up", out_vec[4*32 +: 32], 32'h4B80_0002);
    chk("R6 zero", out_vec[31:0], 32'h0000_0000);
  endtask

  task automatic t_random_rows;
    run_req("R5 R8 row5", 5, 0, 64);
    run_req("R5 R8 row15", 15, 0, 64);
    run_req("R5 R8 row9", 9, 0, 64);
  endtask

  task automatic t_partial;
    run_req("R3 colsb20", 3, 0, 20);
    run_req("R3 colsb22", 3, 0, 22);
    run_req("R3 colsb0", 3, 0, 0);
    run_req("R3 colsb3", 3, 0, 3);
    run_req("R3 colsb60", 0, 0, 60);
    run_req("R3 cap", 2, 0, 200);
  endtask

  task automatic t_out_of_range;
    run_req("R4 chunk1", 1, 1, 64);
    run_req("R4 chunkmax", 1, 65535, 65535);
    run_req("R4 row16", 16, 0, 64);
    run_req("R4 rowmax", 65535, 0, 64);
  endtask

  task automatic t_overwrite;
    wr(0, 0, 32'hFFFF_FF85);
    wr(7, 15, 32'd5);
    run_req("R8 rewrite row0", 0, 0, 64);
    run_req("R8 rewrite row7", 7, 0, 64);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fails++;
    $display("FAIL R7 watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

  initial begin
    rst = 1'b1; req_valid = 1'b0; req_sel = '0; req_colsb = '0;
    wr_en = 1'b0; wr_row = '0; wr_word = '0; wr_data = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst = 1'b0;
    t_load();
    t_reset();
    t_specials();
    t_random_rows();
    t_partial();
    t_out_of_range();
    t_overwrite();
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end
endmodule